// File: doc/BRIEF.md
# DMA Cache-Line Request Splitter

The splitter takes one DMA transfer at a time: a direction, a byte start address and a byte length. It cuts the transfer into a sequence of requests, one per cache line, toward a memory-side controller. Each memory request carries the byte address of the chunk, the line-aligned address, the byte offset inside the line, the chunk length and the direction. Only the first chunk can begin part-way into a line. It is clipped at the end of that line, and every later chunk starts on a line boundary.

For writes, the transfer's bytes arrive on a byte stream and are placed into a line-wide data field at the chunk's offset. For reads, each line-wide data response is unpacked, and the useful bytes leave on an output byte stream in address order. One chunk is outstanding at a time. The next chunk is issued only after the current one completes: a write completes on an acknowledge, and a read completes after its data has been delivered. When all bytes are done, a one-cycle done pulse marks the return to idle.

Top module: `dma_line_splitter`

## Requirements
- R1: Only one transfer is active. `req_ready_o` is high only while idle, a request offered while busy is not taken, and it causes no memory request.
- R2: Every memory request's line address equals its byte address with the low log2(LINE_BYTES) bits cleared. Its offset equals those low bits.
- R3: The first chunk's offset is the start address modulo LINE_BYTES. Its length is the whole transfer length when offset plus length is at most LINE_BYTES, and LINE_BYTES minus offset otherwise.
- R4: Every later chunk starts at start address plus bytes completed. It is line-aligned with offset 0, and its length is the smaller of the remaining bytes and LINE_BYTES.
- R5: For a write chunk, byte lane i of `mem_data_o` (bits [8i+7:8i]) holds the transfer byte for address line+i, for lanes offset to offset+length-1. All other lanes are zero. Write bytes are consumed one per `wr_valid_i`/`wr_ready_o` handshake, in address order.
- R6: A write chunk completes only on a response with `mem_rsp_ack_i`=1, and a read chunk only on a response with `mem_rsp_ack_i`=0. No next request is issued before that response.
- R7: For a read chunk, lanes offset to offset+length-1 of the returned line leave on `rd_data_o`, one per `rd_valid_o`/`rd_ready_i` handshake, in address order.
- R8: After the last chunk completes, `done_o` is high for exactly one cycle. In that same cycle `busy_o` is low and `req_ready_o` is high, and no further memory request follows.
- R9: A transfer of length zero produces a done pulse and no memory request.
- R10: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, every request field holds stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request offered |
| req_ready_o | output | 1 | Transfer request taken (idle) |
| req_write_i | input | 1 | 1 = write transfer, 0 = read |
| req_addr_i | input | ADDR_W | Byte start address |
| req_len_i | input | LEN_W | Byte length |
| wr_valid_i | input | 1 | Write byte available |
| wr_ready_o | output | 1 | Write byte taken |
| wr_data_i | input | 8 | Write byte |
| rd_valid_o | output | 1 | Read byte available |
| rd_ready_i | input | 1 | Read byte taken |
| rd_data_o | output | 8 | Read byte |
| mem_req_valid_o | output | 1 | Line request valid |
| mem_req_ready_i | input | 1 | Line request accepted |
| mem_req_write_o | output | 1 | Line request direction |
| mem_addr_o | output | ADDR_W | Chunk byte address |
| mem_line_o | output | ADDR_W | Line-aligned address |
| mem_off_o | output | log2(LINE_BYTES) | Byte offset in line |
| mem_len_o | output | log2(LINE_BYTES)+1 | Chunk byte count |
| mem_data_o | output | 8*LINE_BYTES | Write line data |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rsp_ready_o | output | 1 | Response accepted |
| mem_rsp_ack_i | input | 1 | 1 = write acknowledge, 0 = read data |
| mem_rsp_data_i | input | 8*LINE_BYTES | Read line data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished pulse |

## Verification
The assertions assume that the memory side returns exactly one response per accepted line request, and that the response kind (acknowledge or data) matches the outstanding request's direction. They also assume that LEN_W is wider than the line offset field. The bench's memory responder replies only after accepting a request. It answers write requests with an acknowledge and read requests with the line data from its own byte array, so a mismatched or unsolicited response never occurs. The bench holds `mem_req_ready_i` low for two cycles before accepting each request, which gives the request-stability property something to check.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEXT,
    ST_FILL,
    ST_ISSUE,
    ST_WAIT,
    ST_DRAIN
  } split_state_e;
endpackage

// File: rtl/dma_chunk_plan.sv
module dma_chunk_plan #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16
) (
  input  logic [ADDR_W-1:0]             start_addr_i,
  input  logic [LEN_W-1:0]              total_len_i,
  input  logic [LEN_W-1:0]              done_cnt_i,
  output logic [ADDR_W-1:0]             cur_addr_o,
  output logic [ADDR_W-1:0]             line_addr_o,
  output logic [$clog2(LINE_BYTES)-1:0] off_o,
  output logic [$clog2(LINE_BYTES):0]   len_o,
  output logic                          all_done_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int CLEN_W = OFF_W + 1;

  logic [LEN_W-1:0]  remaining;
  logic [CLEN_W-1:0] room;
  logic              first;

  assign first       = (done_cnt_i == '0);
  assign cur_addr_o  = start_addr_i + ADDR_W'(done_cnt_i);
  assign line_addr_o = {cur_addr_o[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  // only the first chunk may sit inside a line
  assign off_o       = first ? start_addr_i[OFF_W-1:0] : '0;
  assign room        = CLEN_W'(LINE_BYTES) - CLEN_W'(off_o);
  assign remaining   = total_len_i - done_cnt_i;
  assign len_o       = (remaining < LEN_W'(room)) ? remaining[CLEN_W-1:0] : room;
  assign all_done_o  = (remaining == '0);
endmodule

// File: rtl/dma_line_buf.sv
module dma_line_buf #(
  parameter int LINE_BYTES = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          load_i,
  input  logic [8*LINE_BYTES-1:0]       load_data_i,
  input  logic                          wr_en_i,
  input  logic [$clog2(LINE_BYTES)-1:0] wr_idx_i,
  input  logic [7:0]                    wr_byte_i,
  input  logic [$clog2(LINE_BYTES)-1:0] rd_idx_i,
  output logic [7:0]                    rd_byte_o,
  output logic [8*LINE_BYTES-1:0]       line_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [7:0] lane_q [LINE_BYTES];

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    lane_q[b] <= '0;
      else if (clr_i)                                 lane_q[b] <= '0;
      else if (load_i)                                lane_q[b] <= load_data_i[8*b +: 8];
      else if (wr_en_i && wr_idx_i == OFF_W'(b))      lane_q[b] <= wr_byte_i;
    end
    assign line_o[8*b +: 8] = lane_q[b];
  end

  assign rd_byte_o = lane_q[rd_idx_i];
endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter
  import dma_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic                          req_write_i,
  input  logic [ADDR_W-1:0]             req_addr_i,
  input  logic [LEN_W-1:0]              req_len_i,
  input  logic                          wr_valid_i,
  output logic                          wr_ready_o,
  input  logic [7:0]                    wr_data_i,
  output logic                          rd_valid_o,
  input  logic                          rd_ready_i,
  output logic [7:0]                    rd_data_o,
  output logic                          mem_req_valid_o,
  input  logic                          mem_req_ready_i,
  output logic                          mem_req_write_o,
  output logic [ADDR_W-1:0]             mem_addr_o,
  output logic [ADDR_W-1:0]             mem_line_o,
  output logic [$clog2(LINE_BYTES)-1:0] mem_off_o,
  output logic [$clog2(LINE_BYTES):0]   mem_len_o,
  output logic [8*LINE_BYTES-1:0]       mem_data_o,
  input  logic                          mem_rsp_valid_i,
  output logic                          mem_rsp_ready_o,
  input  logic                          mem_rsp_ack_i,
  input  logic [8*LINE_BYTES-1:0]       mem_rsp_data_i,
  output logic                          busy_o,
  output logic                          done_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int CLEN_W = OFF_W + 1;

  split_state_e      state_q;
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  total_q;
  logic [LEN_W-1:0]  done_cnt_q;
  logic              write_q;
  logic [CLEN_W-1:0] idx_q;
  logic              done_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] line_addr;
  logic [OFF_W-1:0]  chunk_off;
  logic [CLEN_W-1:0] chunk_len;
  logic              all_done;
  logic              last_byte;
  logic              rsp_take;
  logic [OFF_W-1:0]  lane_idx;

  dma_chunk_plan #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .LINE_BYTES(LINE_BYTES)
  ) u_plan (
    .start_addr_i(start_q),
    .total_len_i (total_q),
    .done_cnt_i  (done_cnt_q),
    .cur_addr_o  (cur_addr),
    .line_addr_o (line_addr),
    .off_o       (chunk_off),
    .len_o       (chunk_len),
    .all_done_o  (all_done)
  );

  assign last_byte = (idx_q == chunk_len - CLEN_W'(1));
  assign rsp_take  = (state_q == ST_WAIT) && mem_rsp_valid_i && (mem_rsp_ack_i == write_q);
  assign lane_idx  = chunk_off + idx_q[OFF_W-1:0];

  dma_line_buf #(
    .LINE_BYTES(LINE_BYTES)
  ) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (state_q == ST_NEXT),
    .load_i     (rsp_take && !write_q),
    .load_data_i(mem_rsp_data_i),
    .wr_en_i    ((state_q == ST_FILL) && wr_valid_i),
    .wr_idx_i   (lane_idx),
    .wr_byte_i  (wr_data_i),
    .rd_idx_i   (lane_idx),
    .rd_byte_o  (rd_data_o),
    .line_o     (mem_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      start_q    <= '0;
      total_q    <= '0;
      done_cnt_q <= '0;
      write_q    <= 1'b0;
      idx_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          start_q    <= req_addr_i;
          total_q    <= req_len_i;
          write_q    <= req_write_i;
          done_cnt_q <= '0;
          state_q    <= ST_NEXT;
        end
        ST_NEXT: begin
          idx_q <= '0;
          if (all_done) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= write_q ? ST_FILL : ST_ISSUE;
          end
        end
        ST_FILL: if (wr_valid_i) begin
          if (last_byte) state_q <= ST_ISSUE;
          else           idx_q   <= idx_q + CLEN_W'(1);
        end
        ST_ISSUE: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          if (write_q) begin
            done_cnt_q <= done_cnt_q + LEN_W'(chunk_len);
            state_q    <= ST_NEXT;
          end else begin
            idx_q   <= '0;
            state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (rd_ready_i) begin
          if (last_byte) begin
            done_cnt_q <= done_cnt_q + LEN_W'(chunk_len);
            state_q    <= ST_NEXT;
          end else begin
            idx_q <= idx_q + CLEN_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = done_q;
  assign wr_ready_o      = (state_q == ST_FILL);
  assign rd_valid_o      = (state_q == ST_DRAIN);
  assign mem_req_valid_o = (state_q == ST_ISSUE);
  assign mem_rsp_ready_o = (state_q == ST_WAIT);
  assign mem_req_write_o = write_q;
  assign mem_addr_o      = cur_addr;
  assign mem_line_o      = line_addr;
  assign mem_off_o       = chunk_off;
  assign mem_len_o       = chunk_len;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o)
      && $stable(mem_off_o) && $stable(mem_len_o) && $stable(mem_data_o)); // R10
  AST_OFF_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_addr_o[OFF_W-1:0] == mem_off_o && mem_line_o[OFF_W-1:0] == '0); // R2
  AST_CHUNK_FIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_len_o != '0
      && ({1'b0, mem_len_o} + (CLEN_W+1)'(mem_off_o)) <= (CLEN_W+1)'(LINE_BYTES)); // R3
  AST_LATER_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && done_cnt_q != '0 |-> mem_off_o == '0 && mem_addr_o[OFF_W-1:0] == '0); // R4
  AST_RSP_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i && mem_rsp_ready_o |-> mem_rsp_ack_i == mem_req_write_o); // R6
  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> done_cnt_q <= total_q); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o && !busy_o && !mem_req_valid_o); // R8
  AST_ONE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_valid_i |=> $stable(start_q) && $stable(total_q)); // R1
endmodule

// File: tb/tb_dma_line_splitter.sv
`timescale 1ns/1ps
module tb_dma_line_splitter;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 12;
  localparam int LB     = 16;
  localparam int OFF_W  = 4;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              req_valid_i, req_write_i;
  logic [ADDR_W-1:0] req_addr_i;
  logic [LEN_W-1:0]  req_len_i;
  logic              req_ready_o;
  logic              wr_valid_i, wr_ready_o;
  logic [7:0]        wr_data_i;
  logic              rd_valid_o, rd_ready_i;
  logic [7:0]        rd_data_o;
  logic              mem_req_valid_o, mem_req_ready_i, mem_req_write_o;
  logic [ADDR_W-1:0] mem_addr_o, mem_line_o;
  logic [OFF_W-1:0]  mem_off_o;
  logic [OFF_W:0]    mem_len_o;
  logic [8*LB-1:0]   mem_data_o;
  logic              mem_rsp_valid_i, mem_rsp_ready_o, mem_rsp_ack_i;
  logic [8*LB-1:0]   mem_rsp_data_i;
  logic              busy_o, done_o;

  dma_line_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LB)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data_i),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_write_o(mem_req_write_o), .mem_addr_o(mem_addr_o), .mem_line_o(mem_line_o),
    .mem_off_o(mem_off_o), .mem_len_o(mem_len_o), .mem_data_o(mem_data_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_ready_o(mem_rsp_ready_o),
    .mem_rsp_ack_i(mem_rsp_ack_i), .mem_rsp_data_i(mem_rsp_data_i),
    .busy_o(busy_o), .done_o(done_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [7:0] mem [1024];
  logic [7:0] expm [1024];

  int log_n = 0;
  longint log_addr [64];
  int log_off [64];
  int log_len [64];
  bit log_wr [64];

  // memory-side responder
  logic [ADDR_W-1:0] s_addr, s_line;
  logic [OFF_W-1:0]  s_off;
  logic [OFF_W:0]    s_len;
  logic [8*LB-1:0]   s_data;
  logic              s_wr;
  bit hold_ok, lanes_ok, quiet;

  initial begin
    mem_req_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_ack_i   = 1'b0;
    mem_rsp_data_i  = '0;
    forever begin
      @(negedge clk);
      if (rst_ni && mem_req_valid_o) begin
        s_addr = mem_addr_o; s_line = mem_line_o; s_off = mem_off_o;
        s_len = mem_len_o; s_data = mem_data_o; s_wr = mem_req_write_o;
        chk(s_line == (s_addr & ~32'hF), "R2 line address", s_line, s_addr & ~32'hF);
        hold_ok = 1;
        repeat (2) begin
          @(negedge clk);
          if (!(mem_req_valid_o && mem_addr_o == s_addr && mem_off_o == s_off &&
                mem_len_o == s_len && mem_data_o == s_data && mem_req_write_o == s_wr))
            hold_ok = 0;
        end
        chk(hold_ok, "R10 request hold", hold_ok, 1);
        mem_req_ready_i = 1'b1;
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        if (log_n < 64) begin
          log_addr[log_n] = s_addr; log_off[log_n] = s_off;
          log_len[log_n] = s_len; log_wr[log_n] = s_wr;
        end
        log_n++;
        if (s_wr) begin
          lanes_ok = 1;
          for (int b = 0; b < LB; b++) begin
            if (b >= s_off && b < s_off + s_len) mem[(s_line + b) % 1024] = s_data[8*b +: 8];
            else if (s_data[8*b +: 8] != 8'h00) lanes_ok = 0;
          end
          chk(lanes_ok, "R5 unused lanes zero", lanes_ok, 1);
        end
        quiet = 1;
        repeat (2) begin
          if (mem_req_valid_o) quiet = 0;
          @(negedge clk);
        end
        chk(quiet, "R6 no request before response", quiet, 1);
        for (int b = 0; b < LB; b++) mem_rsp_data_i[8*b +: 8] = mem[(s_line + b) % 1024];
        mem_rsp_ack_i   = s_wr;
        mem_rsp_valid_i = 1'b1;
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
      end
    end
  end

  function automatic logic [7:0] wpat(int seed, int k);
    return 8'((seed * 31 + k * 13 + 7) & 255);
  endfunction

  task automatic run_xfer(input bit w, input int addr, input int len, input bit bp,
                          input bit poke, input int seed);
    int start_n, k, cyc, cur, rem, off, l, idx;
    bit got_done, busy_ok, hs_w, hs_r, rd_ok, mem_ok;
    start_n = log_n;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R1 ready when idle", req_ready_o, 1);
    req_valid_i = 1'b1; req_write_i = w; req_addr_i = addr; req_len_i = len;
    @(negedge clk);
    req_valid_i = 1'b0;
    k = 0; cyc = 0; got_done = 0; busy_ok = 1; rd_ok = 1;
    while (cyc < 5000) begin
      if (done_o) begin
        got_done = 1;
        req_valid_i = 1'b0;
        break;
      end
      if (poke) begin
        req_valid_i = 1'b1; req_write_i = ~w; req_addr_i = 900; req_len_i = 5;
        if (req_ready_o) busy_ok = 0;
      end
      rd_ready_i = bp ? cyc[0] : 1'b1;
      wr_valid_i = w && (k < len);
      wr_data_i  = wpat(seed, k);
      hs_w = w && wr_valid_i && wr_ready_o;
      hs_r = rd_valid_o && rd_ready_i;
      if (hs_r) begin
        if (rd_data_o != mem[(addr + k) % 1024]) begin
          rd_ok = 0;
          chk(0, "R7 read byte", rd_data_o, mem[(addr + k) % 1024]);
        end
        k++;
      end
      if (hs_w) begin
        expm[(addr + k) % 1024] = wpat(seed, k);
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    wr_valid_i = 1'b0;
    rd_ready_i = 1'b0;
    chk(got_done, "R8 done pulse seen", got_done, 1);
    chk(!busy_o && req_ready_o, "R8 idle with done", busy_o, 0);
    if (poke) chk(busy_ok, "R1 not ready while busy", busy_ok, 1);
    if (w) chk(k == len, "R5 write bytes consumed", k, len);
    else   chk(k == len && rd_ok, "R7 read bytes delivered", k, len);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    cur = addr; rem = len; idx = start_n;
    while (rem > 0) begin
      off = cur % LB;
      l = (rem < LB - off) ? rem : LB - off;
      if (idx < 64) begin
        if (idx == start_n) begin
          chk(log_addr[idx] == cur && log_off[idx] == off, "R3 first chunk offset", log_off[idx], off);
          chk(log_len[idx] == l, "R3 first chunk length", log_len[idx], l);
        end else begin
          chk(log_addr[idx] == cur && log_off[idx] == 0, "R4 later chunk aligned", log_addr[idx], cur);
          chk(log_len[idx] == l, "R4 later chunk length", log_len[idx], l);
        end
        chk(log_wr[idx] == w, "R6 chunk direction", log_wr[idx], w);
      end
      cur += l; rem -= l; idx++;
    end
    repeat (8) @(negedge clk);
    chk(log_n == idx, "R8 chunk count, no extra request", log_n, idx);
    if (w) begin
      mem_ok = 1;
      for (int a = 0; a < 1024; a++) if (mem[a] != expm[a]) mem_ok = 0;
      chk(mem_ok, "R5 memory contents after write", mem_ok, 1);
    end
  endtask

  task automatic t_reset();
    chk(busy_o == 0, "R8 reset busy", busy_o, 0);
    chk(req_ready_o == 1, "R1 reset ready", req_ready_o, 1);
    chk(mem_req_valid_o == 0, "R6 reset no request", mem_req_valid_o, 0);
    chk(done_o == 0 && rd_valid_o == 0 && wr_ready_o == 0, "R8 reset outputs", done_o, 0);
  endtask

  task automatic t_read_aligned();      run_xfer(0, 64, 32, 0, 0, 0);  endtask // R4
  task automatic t_read_inside_line();  run_xfer(0, 101, 7, 0, 0, 0);  endtask // R3
  task automatic t_read_exact_end();    run_xfer(0, 138, 6, 0, 0, 0);  endtask // R3 boundary
  task automatic t_read_one_over();     run_xfer(0, 138, 7, 0, 0, 0);  endtask // R3 R4
  task automatic t_read_long_busy();    run_xfer(0, 203, 45, 1, 1, 0); endtask // R1 R7
  task automatic t_write_unaligned();   run_xfer(1, 307, 23, 0, 0, 3); endtask // R5
  task automatic t_write_full_line();   run_xfer(1, 400, 16, 0, 1, 5); endtask // R5 R1
  task automatic t_write_short();       run_xfer(1, 515, 3, 0, 0, 9);  endtask // R5
  task automatic t_readback();          run_xfer(0, 300, 40, 1, 0, 0); endtask // R7

  task automatic t_zero_len();
    int start_n, cyc;
    bit seen;
    start_n = log_n;
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = 77; req_len_i = 0;
    @(negedge clk);
    req_valid_i = 1'b0;
    seen = 0;
    for (cyc = 0; cyc < 10; cyc++) begin
      if (done_o) seen = 1;
      @(negedge clk);
    end
    chk(seen, "R9 zero length done", seen, 1);
    chk(log_n == start_n && !mem_req_valid_o, "R9 zero length no request", log_n, start_n);
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) begin
      mem[a]  = 8'((a * 7 + 3) & 255);
      expm[a] = 8'((a * 7 + 3) & 255);
    end
    rst_ni = 1'b0;
    req_valid_i = 0; req_write_i = 0; req_addr_i = '0; req_len_i = '0;
    wr_valid_i = 0; wr_data_i = '0; rd_ready_i = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_read_aligned();
    t_read_inside_line();
    t_read_exact_end();
    t_read_one_over();
    t_read_long_busy();
    t_write_unaligned();
    t_write_full_line();
    t_write_short();
    t_zero_len();
    t_readback();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule